// File: doc/BRIEF.md
# Address-Threshold Write Protection Unit

This block sits between the command decoder of a small serial non-volatile memory and its 64-word storage array. It decides, for every write-type command, whether the command may take effect. It keeps three pieces of state: a write-enable latch for array writes, a 6-bit boundary register that holds the lowest protected address, and a one-way freeze that makes the boundary permanent. A self-timed program timer reports busy while a granted write is being programmed.

A command arrives as a one-cycle `cmd_valid` with a 3-bit opcode, a word address and a boundary value, qualified by the program-enable pin `prog_en`. One clock edge later the unit raises `wr_grant` for one cycle if an array write was accepted, and `busy` stays high for `PROG_CYCLES` cycles for any accepted programming operation (array write, fill, boundary load, boundary clear, freeze). Boundary value all-ones means no address is protected.

Three state machines make up the unit. The write latch has states WL_OFF and WL_ON: the enable command moves WL_OFF to WL_ON, the disable command moves it back. The boundary access machine has states PR_CLOSED, PR_OPEN and PR_FROZEN: the boundary-enable command moves PR_CLOSED to PR_OPEN, an accepted freeze moves PR_OPEN to PR_FROZEN, and PR_FROZEN is left only by reset. The program timer has states ST_IDLE and ST_PROG: an accepted programming operation moves ST_IDLE to ST_PROG, and expiry of the cycle counter moves ST_PROG back to ST_IDLE.

Top module: `wprot_unit`

## Requirements
- R1: After reset `busy` and `wr_grant` are 0, `prot_bound` is all-ones (63) and the write latch is off, so an array write issued before any enable command is refused.
- R2: Opcodes are 0 enable-latch, 1 disable-latch, 2 array write, 3 fill-all, 4 boundary-enable, 5 boundary load, 6 boundary clear, 7 freeze. An array write with `prog_en` high, latch on, not busy and an unprotected address raises `wr_grant` for exactly one cycle, one edge after the command, with `wr_grant_all` low.
- R3: When `prot_bound` is not all-ones, an array write to an address greater than or equal to `prot_bound` is refused; an address below it is granted; with all-ones every address, 63 included, is writable.
- R4: With `prog_en` low, no command changes any state: writes, fill, latch enable, boundary enable, load, clear and freeze are all ignored.
- R5: The enable-latch command turns on array writes and the disable-latch command turns them off; while off, array writes and fill are refused.
- R6: Boundary load, clear and freeze are refused until a boundary-enable command with `prog_en` high has been accepted since reset.
- R7: An accepted boundary load copies `cmd_bound` into `prot_bound` on the command edge; an accepted clear sets it to all-ones.
- R8: After an accepted freeze, boundary load and clear have no effect for the rest of the session, and `prot_bound` never changes again.
- R9: Every accepted programming operation holds `busy` high for exactly `PROG_CYCLES` cycles starting one edge after the command; any write-type command presented while `busy` is high is refused with no state change.
- R10: Fill-all is refused when `prot_bound` is not all-ones; otherwise it raises `wr_grant` and `wr_grant_all` together for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command opcode (R2 encoding) |
| cmd_addr | input | ADDR_W | Target word address for array write |
| cmd_bound | input | ADDR_W | New boundary value for boundary load |
| prog_en | input | 1 | Program-enable pin; low blocks all writes |
| wr_grant | output | 1 | One-cycle grant to the array for a write |
| wr_grant_all | output | 1 | Qualifies a grant as a whole-array fill |
| prot_bound | output | ADDR_W | Current lowest protected address |
| busy | output | 1 | Programming in progress |

## Verification
The two functions that collide are the expiry of the program timer and the arrival of a new write request: a command presented on the last busy cycle is sampled on the same edge where the timer returns to idle. The bench counts busy cycles after a granted write, issues another write exactly on the final busy cycle and expects it to be refused with no grant, then issues it again one cycle later and expects a grant. A boundary load presented during busy is judged the same way, by `prot_bound` staying unchanged.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [2:0] {
        OP_LATCH_ON  = 3'd0,
        OP_LATCH_OFF = 3'd1,
        OP_WRITE     = 3'd2,
        OP_FILL      = 3'd3,
        OP_BND_OPEN  = 3'd4,
        OP_BND_LOAD  = 3'd5,
        OP_BND_CLEAR = 3'd6,
        OP_FREEZE    = 3'd7
    } op_e;

    typedef enum logic {
        WL_OFF = 1'b0,
        WL_ON  = 1'b1
    } latch_state_e;

    typedef enum logic [1:0] {
        PR_CLOSED = 2'd0,
        PR_OPEN   = 2'd1,
        PR_FROZEN = 2'd2
    } bnd_state_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PROG = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic latch_on;
        logic latch_off;
        logic write;
        logic fill;
        logic bnd_open;
        logic bnd_load;
        logic bnd_clear;
        logic freeze;
    } accept_t;

endpackage

// File: rtl/wprot_gate.sv
module wprot_gate
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] bound,
    input  logic              latch_on,
    input  logic              bnd_open,
    input  logic              busy,
    output accept_t           acc
);
    localparam logic [ADDR_W-1:0] NONE_PROTECTED = {ADDR_W{1'b1}};

    logic addr_guarded;
    logic any_guarded;
    logic may_program;
    logic may_touch_bnd;

    always_comb begin
        addr_guarded  = (bound != NONE_PROTECTED) && (cmd_addr >= bound);
        any_guarded   = (bound != NONE_PROTECTED);
        may_program   = cmd_valid && prog_en && !busy;
        may_touch_bnd = may_program && bnd_open;
    end

    always_comb begin
        acc = '0;
        if (cmd_valid) begin
            unique case (op_e'(cmd_op))
                OP_LATCH_ON:  acc.latch_on  = prog_en;
                OP_LATCH_OFF: acc.latch_off = prog_en;
                OP_WRITE:     acc.write     = may_program && latch_on && !addr_guarded;
                OP_FILL:      acc.fill      = may_program && latch_on && !any_guarded;
                OP_BND_OPEN:  acc.bnd_open  = prog_en;
                OP_BND_LOAD:  acc.bnd_load  = may_touch_bnd;
                OP_BND_CLEAR: acc.bnd_clear = may_touch_bnd;
                OP_FREEZE:    acc.freeze    = may_touch_bnd;
                default:      acc = '0;
            endcase
        end
    end

endmodule

// File: rtl/wprot_boundary.sv
module wprot_boundary
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  accept_t           acc,
    input  logic [ADDR_W-1:0] cmd_bound,
    output logic              latch_on,
    output logic              bnd_open,
    output logic              frozen,
    output logic [ADDR_W-1:0] bound
);
    localparam logic [ADDR_W-1:0] NONE_PROTECTED = {ADDR_W{1'b1}};

    latch_state_e wl_q, wl_d;
    bnd_state_e   pr_q, pr_d;
    logic [ADDR_W-1:0] bound_q, bound_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wl_q    <= WL_OFF;
            pr_q    <= PR_CLOSED;
            bound_q <= NONE_PROTECTED;
        end else begin
            wl_q    <= wl_d;
            pr_q    <= pr_d;
            bound_q <= bound_d;
        end
    end

    always_comb begin
        wl_d = wl_q;
        unique case (wl_q)
            WL_OFF: if (acc.latch_on)  wl_d = WL_ON;
            WL_ON:  if (acc.latch_off) wl_d = WL_OFF;
            default: wl_d = WL_OFF;
        endcase
    end

    always_comb begin
        pr_d    = pr_q;
        bound_d = bound_q;
        unique case (pr_q)
            PR_CLOSED: begin
                if (acc.bnd_open) pr_d = PR_OPEN;
            end
            PR_OPEN: begin
                if (acc.bnd_load)       bound_d = cmd_bound;
                else if (acc.bnd_clear) bound_d = NONE_PROTECTED;
                if (acc.freeze)         pr_d = PR_FROZEN;
            end
            PR_FROZEN: begin
                pr_d = PR_FROZEN;
            end
            default: pr_d = PR_CLOSED;
        endcase
    end

    always_comb begin
        latch_on = (wl_q == WL_ON);
        bnd_open = (pr_q == PR_OPEN);
        frozen   = (pr_q == PR_FROZEN);
        bound    = bound_q;
    end

endmodule

// File: rtl/wprot_timer.sv
module wprot_timer
    import wprot_pkg::*;
#(
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_array,
    input  logic start_fill,
    input  logic start_other,
    output logic busy,
    output logic grant,
    output logic grant_all
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    tmr_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic kick;

    always_comb kick = start_array || start_fill || start_other;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (kick) begin
                    st_d  = ST_PROG;
                    cnt_d = LAST;
                end
            end
            ST_PROG: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant     <= 1'b0;
            grant_all <= 1'b0;
        end else begin
            grant     <= (st_q == ST_IDLE) && (start_array || start_fill);
            grant_all <= (st_q == ST_IDLE) && start_fill;
        end
    end

    always_comb busy = (st_q == ST_PROG);

endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
    import wprot_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int PROG_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] cmd_bound,
    input  logic              prog_en,
    output logic              wr_grant,
    output logic              wr_grant_all,
    output logic [ADDR_W-1:0] prot_bound,
    output logic              busy
);
    accept_t acc;
    logic    latch_on;
    logic    bnd_open;
    logic    frozen;

    wprot_gate #(.ADDR_W(ADDR_W)) u_gate (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .prog_en   (prog_en),
        .bound     (prot_bound),
        .latch_on  (latch_on),
        .bnd_open  (bnd_open),
        .busy      (busy),
        .acc       (acc)
    );

    wprot_boundary #(.ADDR_W(ADDR_W)) u_boundary (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .cmd_bound (cmd_bound),
        .latch_on  (latch_on),
        .bnd_open  (bnd_open),
        .frozen    (frozen),
        .bound     (prot_bound)
    );

    wprot_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_array (acc.write),
        .start_fill  (acc.fill),
        .start_other (acc.bnd_load || acc.bnd_clear || acc.freeze),
        .busy        (busy),
        .grant       (wr_grant),
        .grant_all   (wr_grant_all)
    );

endmodule

// File: rtl/wprot_unit_chk.sv
module wprot_unit_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              prog_en,
    input logic              wr_grant,
    input logic              wr_grant_all,
    input logic [ADDR_W-1:0] prot_bound,
    input logic              busy,
    input logic              frozen
);
    localparam logic [ADDR_W-1:0] ALL1 = {ADDR_W{1'b1}};

    // R2
    grant_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |=> !wr_grant);

    // R9
    grant_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |-> busy);

    // R9
    no_grant_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> !wr_grant);

    // R3
    guarded_addr_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2 && prot_bound != ALL1 && cmd_addr >= prot_bound)
        |=> !wr_grant);

    // R4
    pe_low_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !prog_en) |=> (!wr_grant && $stable(prot_bound)));

    // R8
    frozen_bound_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(prot_bound));

    // R10
    fill_unguarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant_all |-> (wr_grant && prot_bound == ALL1));

endmodule

bind wprot_unit wprot_unit_chk #(.ADDR_W(ADDR_W)) u_wprot_unit_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_addr     (cmd_addr),
    .prog_en      (prog_en),
    .wr_grant     (wr_grant),
    .wr_grant_all (wr_grant_all),
    .prot_bound   (prot_bound),
    .busy         (busy),
    .frozen       (frozen)
);

// File: tb/test_wprot_unit.sv
module test_wprot_unit;
    import wprot_pkg::*;

    localparam int AW = 6;
    localparam int NCYC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [AW-1:0] cmd_bound = '0;
    logic          prog_en = 1'b1;
    logic          wr_grant;
    logic          wr_grant_all;
    logic [AW-1:0] prot_bound;
    logic          busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    wprot_unit #(.ADDR_W(AW), .PROG_CYCLES(NCYC)) i_wprot_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bound(cmd_bound), .prog_en(prog_en),
        .wr_grant(wr_grant), .wr_grant_all(wr_grant_all),
        .prot_bound(prot_bound), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input op_e op, input int a, input int d, input logic pe);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = AW'(a);
        cmd_bound = AW'(d);
        prog_en   = pe;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        prog_en   = 1'b1;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 grant", wr_grant, 0);
        check("R1 bound", prot_bound, 63);
        issue(OP_WRITE, 5, 0, 1'b1);
        check("R1 write without latch", wr_grant, 0);
        check("R1 no busy", busy, 0);
    endtask

    task automatic t_basic_write();
        int cnt;
        issue(OP_LATCH_ON, 0, 0, 1'b1);
        issue(OP_WRITE, 5, 0, 1'b1);
        check("R2 grant", wr_grant, 1);
        check("R2 grant_all low", wr_grant_all, 0);
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
            if (cnt == 1) check("R2 grant one cycle", wr_grant, 0);
        end
        check("R9 busy length", cnt, NCYC);
        issue(OP_WRITE, 63, 0, 1'b1);
        check("R3 addr 63 with all-ones bound", wr_grant, 1);
        wait_idle();
    endtask

    task automatic t_bound_access();
        issue(OP_BND_LOAD, 0, 40, 1'b1);
        check("R6 load before open", prot_bound, 63);
        check("R6 no busy", busy, 0);
        issue(OP_BND_OPEN, 0, 0, 1'b0);
        issue(OP_BND_LOAD, 0, 40, 1'b1);
        check("R4 open with pe low ignored", prot_bound, 63);
        issue(OP_BND_OPEN, 0, 0, 1'b1);
        issue(OP_BND_LOAD, 0, 40, 1'b0);
        check("R4 load with pe low", prot_bound, 63);
        issue(OP_BND_LOAD, 0, 40, 1'b1);
        check("R7 load", prot_bound, 40);
        check("R9 busy after load", busy, 1);
        wait_idle();
        issue(OP_WRITE, 7, 0, 1'b0);
        check("R4 write with pe low", wr_grant, 0);
        check("R4 no busy", busy, 0);
    endtask

    task automatic t_boundary();
        issue(OP_WRITE, 39, 0, 1'b1);
        check("R3 below bound", wr_grant, 1);
        wait_idle();
        issue(OP_WRITE, 40, 0, 1'b1);
        check("R3 at bound", wr_grant, 0);
        issue(OP_WRITE, 63, 0, 1'b1);
        check("R3 above bound", wr_grant, 0);
        issue(OP_FILL, 0, 0, 1'b1);
        check("R10 fill guarded", wr_grant, 0);
        check("R10 fill no busy", busy, 0);
    endtask

    task automatic t_latch();
        issue(OP_LATCH_OFF, 0, 0, 1'b1);
        issue(OP_WRITE, 3, 0, 1'b1);
        check("R5 write after disable", wr_grant, 0);
        issue(OP_LATCH_ON, 0, 0, 1'b0);
        issue(OP_WRITE, 3, 0, 1'b1);
        check("R4 enable with pe low", wr_grant, 0);
        issue(OP_LATCH_ON, 0, 0, 1'b1);
        issue(OP_WRITE, 3, 0, 1'b1);
        check("R5 write after enable", wr_grant, 1);
        wait_idle();
    endtask

    task automatic t_clear_fill();
        issue(OP_BND_CLEAR, 0, 0, 1'b1);
        check("R7 clear", prot_bound, 63);
        wait_idle();
        issue(OP_FILL, 0, 0, 1'b1);
        check("R10 fill grant", wr_grant, 1);
        check("R10 fill flag", wr_grant_all, 1);
        wait_idle();
    endtask

    task automatic t_overlap();
        issue(OP_WRITE, 1, 0, 1'b1);
        check("R2 grant before overlap", wr_grant, 1);
        repeat (NCYC - 1) @(negedge clk);
        check("R9 last busy cycle", busy, 1);
        issue(OP_WRITE, 2, 0, 1'b1);
        check("R9 write on final busy cycle", wr_grant, 0);
        check("R9 idle after expiry", busy, 0);
        issue(OP_WRITE, 2, 0, 1'b1);
        check("R9 write right after", wr_grant, 1);
        repeat (3) @(negedge clk);
        issue(OP_BND_LOAD, 0, 10, 1'b1);
        check("R9 load during busy", prot_bound, 63);
        wait_idle();
    endtask

    task automatic t_freeze();
        issue(OP_BND_LOAD, 0, 20, 1'b1);
        check("R7 load 20", prot_bound, 20);
        wait_idle();
        issue(OP_FREEZE, 0, 0, 1'b1);
        check("R9 freeze busy", busy, 1);
        wait_idle();
        issue(OP_BND_LOAD, 0, 30, 1'b1);
        check("R8 load after freeze", prot_bound, 20);
        check("R8 no busy", busy, 0);
        issue(OP_BND_CLEAR, 0, 0, 1'b1);
        check("R8 clear after freeze", prot_bound, 20);
        issue(OP_WRITE, 25, 0, 1'b1);
        check("R3 guarded under freeze", wr_grant, 0);
        issue(OP_WRITE, 19, 0, 1'b1);
        check("R3 below frozen bound", wr_grant, 1);
        wait_idle();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_write();
        t_bound_access();
        t_boundary();
        t_latch();
        t_clear_fill();
        t_overlap();
        t_freeze();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

endmodule